// File: doc/BRIEF.md
# Serial LED Dot-Matrix Chain Writer

This block sits on the host side of a chain of serially cascaded LED dot-matrix driver devices. It drives the shared control lines (chip enable, register select, bit clock, blank and device reset) and the serial data line that feeds the first device of the chain. A requester hands it either a full pixel buffer for the whole chain or one 8-bit control word. The block turns the request into a framed bit stream at a bit rate set by parameters. It orders the edges so that the receiving devices latch the data when the frame closes.

After its own reset the block first runs the power-up sequence. It pulses the device reset, clears every dot bit in the chain to zero, and then writes control word 0 with the chosen brightness and the wake bit set. Only after that does it release blanking and accept requests. The block also follows whether the chain has been put into broadcast mode, where every device passes its input straight on during control writes. It shortens control frames from N_DEV×8 clocks to 8 clocks while that mode is active.

Top module: `led_chain_writer`

## Requirements
- R1: While `rst_n` is low, `disp_rst_n` and `req_ready` are low, `disp_ce` is high, `disp_clk` is low and `disp_blank` is high. After `rst_n` rises, `disp_rst_n` goes high on the RST_CYC-th rising clock edge.
- R2: After reset the block sends a dot frame of 160×N_DEV zero bits. It then sends a serial control frame carrying the word {0,1,init_level[5:0]} once per device (N_DEV×8 clocks). Only then does `disp_blank` go low and `req_ready` go high.
- R3: A dot write (`req_ctrl`=0) keeps `disp_rs` low and sends exactly 160×N_DEV bits, starting at `req_dots[MSB]` and ending at bit 0. The left-most character therefore occupies the top 40 bits, as five column bytes from left to right, each byte sent MSB first, and bit 0 of each byte is the unused bottom row.
- R4: A control write (`req_ctrl`=1) in serial mode keeps `disp_rs` high and sends `req_word` MSB first, repeated N_DEV times, in N_DEV×8 clocks. Every device then holds the word, in word 1 if bit 7 is 1 and in word 0 otherwise.
- R5: A completed control write with bit 7 = 1 sets broadcast mode to that word's bit 0. While broadcast mode is set, control writes use 8 clocks. Dot writes always use the full length. A reset clears broadcast mode.
- R6: `disp_rs` settles at least SETUP cycles before `disp_ce` falls and is constant while `disp_ce` is low. The first rising `disp_clk` comes exactly SETUP+HALF cycles after `disp_ce` falls. `disp_clk` rises only while `disp_ce` is low.
- R7: Within a frame, each clock low phase and each clock high phase lasts HALF cycles. `disp_din` changes only while `disp_clk` is low.
- R8: A frame ends with `disp_ce` rising HALF cycles after the last rising `disp_clk`, while the clock is still high. `disp_clk` falls SETUP cycles after that, which latches the data.
- R9: `req_ready` is high only when the block is idle, with `disp_ce` high and `disp_clk` low. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` while `req_ready` is low starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ctrl | input | 1 | 1 = control word write, 0 = dot buffer write |
| req_word | input | 8 | Control word, bit 7 selects word 1 |
| req_dots | input | 160×N_DEV | Pixel buffer, left-most character in the top bits |
| init_level | input | 6 | Brightness bits for the power-up control word |
| req_ready | output | 1 | Idle and able to take a request |
| disp_rst_n | output | 1 | Device reset, active low |
| disp_ce | output | 1 | Chip enable, active low |
| disp_rs | output | 1 | Register select, 1 = control |
| disp_clk | output | 1 | Serial bit clock |
| disp_din | output | 1 | Serial data into the first device |
| disp_blank | output | 1 | Blanking, high until power-up completes |

## Verification
The assertions assume that SETUP and HALF are at least 1, and that the requester changes `req_*` only while `req_ready` is high or `req_valid` is low. The bench drives every request at the falling clock edge and only raises `req_valid` after it has seen `req_ready`. The one exception is a burst it sends on purpose while the block is busy. The bench models the device chain, including the broadcast pass-through of each device, so each control frame is judged by what every device latches. The bench also times every edge against SETUP and HALF.

// File: rtl/led_chain_writer.sv
`timescale 1ns/1ps
module led_chain_writer #(
  parameter int N_DEV   = 2,
  parameter int HALF    = 3,
  parameter int SETUP   = 2,
  parameter int RST_CYC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_ctrl,
  input  logic [7:0]             req_word,
  input  logic [160*N_DEV-1:0]   req_dots,
  input  logic [5:0]             init_level,
  output logic                   req_ready,
  output logic                   disp_rst_n,
  output logic                   disp_ce,
  output logic                   disp_rs,
  output logic                   disp_clk,
  output logic                   disp_din,
  output logic                   disp_blank
);
  localparam int DOT_W = 160 * N_DEV;
  localparam int CW    = $clog2(DOT_W + 1);

  typedef enum logic [2:0] {S_RST, S_IDLE, S_RS, S_CE, S_LO, S_HI, S_CEUP, S_END} st_t;

  st_t              st;
  logic [15:0]      tmr;
  logic [DOT_W-1:0] sh;
  logic [CW-1:0]    left;
  logic [1:0]       init;
  logic             bcast, kind, w7, w0;

  logic             done, go, go_ctrl;
  logic [7:0]       go_word;
  logic [DOT_W-1:0] go_img;
  logic [CW-1:0]    go_len;

  assign done       = (tmr == 16'd0);
  assign req_ready  = (st == S_IDLE);
  assign disp_rst_n = (st != S_RST);
  assign disp_blank = (init != 2'd2);
  assign disp_din   = sh[DOT_W-1];

  always_comb begin
    go      = 1'b0;
    go_ctrl = 1'b0;
    go_word = req_word;
    go_img  = req_dots;
    if (st == S_RST && done) begin
      go     = 1'b1;
      go_img = '0;
    end else if (st == S_END && done && init == 2'd0) begin
      go      = 1'b1;
      go_ctrl = 1'b1;
      go_word = {2'b01, init_level};
    end else if (st == S_IDLE && req_valid) begin
      go      = 1'b1;
      go_ctrl = req_ctrl;
    end
    if (go_ctrl) go_img = {{N_DEV{go_word}}, {(DOT_W - 8*N_DEV){1'b0}}};
    go_len = go_ctrl ? (bcast ? CW'(8) : CW'(8*N_DEV)) : CW'(DOT_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_RST; tmr <= 16'(RST_CYC-1); sh <= '0; left <= '0;
      init <= 2'd0; bcast <= 1'b0; kind <= 1'b0; w7 <= 1'b0; w0 <= 1'b0;
      disp_ce <= 1'b1; disp_rs <= 1'b0; disp_clk <= 1'b0;
    end else begin
      if (st == S_END && done) begin
        if (kind && w7) bcast <= w0;
        init <= (init == 2'd0) ? 2'd1 : 2'd2;
      end
      if (go) begin
        sh <= go_img; left <= go_len; kind <= go_ctrl;
        w7 <= go_word[7]; w0 <= go_word[0];
        disp_rs <= go_ctrl; st <= S_RS; tmr <= 16'(SETUP-1);
      end else if (!done) begin
        tmr <= tmr - 16'd1;
      end else begin
        case (st)
          S_RS:   begin disp_ce <= 1'b0; st <= S_CE; tmr <= 16'(SETUP-1); end
          S_CE:   begin st <= S_LO; tmr <= 16'(HALF-1); end
          S_LO:   begin disp_clk <= 1'b1; st <= S_HI; tmr <= 16'(HALF-1); end
          S_HI:
            if (left == CW'(1)) begin
              disp_ce <= 1'b1; st <= S_CEUP; tmr <= 16'(SETUP-1);
            end else begin
              disp_clk <= 1'b0; sh <= sh << 1; left <= left - CW'(1);
              st <= S_LO; tmr <= 16'(HALF-1);
            end
          S_CEUP: begin disp_clk <= 1'b0; st <= S_END; tmr <= 16'(SETUP-1); end
          S_END:  st <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  assert_rs_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_ce && !$past(disp_ce) |-> $stable(disp_rs));
  assert_clk_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_clk) |-> !disp_ce);
  assert_din_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_clk && $past(disp_clk) |-> $stable(disp_din));
  assert_ce_up_clk_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_ce) |-> disp_clk);
  assert_clk_low_after_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_ce) |=> disp_ce);
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> disp_ce && !disp_clk);
endmodule

// File: tb/led_chain_writer_bench.sv
`timescale 1ns/1ps
module led_chain_writer_bench;
  localparam int N = 2, HALF = 2, SETUP = 1, RST_CYC = 3;
  localparam int DOT_W = 160 * N;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, req_ctrl = 1'b0;
  logic [7:0] req_word = 8'h00;
  logic [DOT_W-1:0] req_dots = '0;
  logic [5:0] init_level = 6'b101101;
  logic req_ready, disp_rst_n, disp_ce, disp_rs, disp_clk, disp_din, disp_blank;

  always #10 clk = ~clk;

  led_chain_writer #(.N_DEV(N), .HALF(HALF), .SETUP(SETUP), .RST_CYC(RST_CYC)) u_led_chain_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctrl(req_ctrl),
    .req_word(req_word), .req_dots(req_dots), .init_level(init_level),
    .req_ready(req_ready), .disp_rst_n(disp_rst_n), .disp_ce(disp_ce),
    .disp_rs(disp_rs), .disp_clk(disp_clk), .disp_din(disp_din), .disp_blank(disp_blank));

  int total = 0, bad = 0;
  int cyc = 0, v6 = 0, v7 = 0, v8 = 0, xfers = 0, clks = 0, last_clks = 0;
  int rs_chg = 0, ce_fall = 0, ce_rise = 0, rise_c = 0, fall_c = 0;
  logic p_ce = 1'b1, p_ck = 1'b0, p_rs = 1'b0, p_din = 1'b0, din_rise = 1'b0;
  logic m_rs = 1'b0, m_pend = 1'b0;
  logic [DOT_W-1:0] m_sr = '1, m_lat = '1;
  logic [7:0] m_csr [N], m_cw0 [N], m_cw1 [N];
  logic [N-1:0] m_ins;

  initial for (int k = 0; k < N; k++) begin m_csr[k] = 8'hFF; m_cw0[k] = 8'hFF; m_cw1[k] = 8'hFF; end

  always @(negedge clk) begin
    cyc++;
    if (!disp_rst_n) for (int k = 0; k < N; k++) begin m_cw0[k] = 8'h00; m_cw1[k] = 8'h00; end
    if (rst_n) begin
      if (disp_rs != p_rs) begin rs_chg = cyc; if (!disp_ce) v6++; end
      if (p_ce && !disp_ce) begin
        m_rs = disp_rs; clks = 0; ce_fall = cyc;
        if (rs_chg > ce_rise && cyc - rs_chg < SETUP) v6++;
      end
      if (p_ck && disp_ck_hi()) begin if (disp_din != p_din) v7++; end
      if (!p_ck && disp_clk) begin
        if (disp_ce) v6++;
        else begin
          clks++;
          if (clks == 1) begin if (cyc - ce_fall != SETUP + HALF) v6++; end
          else if (cyc - fall_c != HALF) v7++;
          rise_c = cyc; din_rise = disp_din;
          if (!m_rs) m_sr = {m_sr[DOT_W-2:0], disp_din};
          else begin
            m_ins[0] = disp_din;
            for (int k = 1; k < N; k++) m_ins[k] = m_cw1[k-1][0] ? m_ins[k-1] : m_csr[k-1][7];
            for (int k = 0; k < N; k++) m_csr[k] = {m_csr[k][6:0], m_ins[k]};
          end
        end
      end
      if (!p_ce && disp_ce) begin
        if (!disp_clk || cyc - rise_c != HALF) v8++;
        m_pend = 1'b1; ce_rise = cyc; last_clks = clks; xfers++;
      end
      if (p_ck && !disp_clk) begin
        if (p_din != din_rise) v7++;
        if (!disp_ce) begin if (cyc - rise_c != HALF) v7++; end
        else if (cyc - ce_rise != SETUP) v8++;
        fall_c = cyc;
      end
      if (m_pend && disp_ce && !disp_clk) begin
        m_pend = 1'b0;
        if (!m_rs) m_lat = m_sr;
        else for (int k = 0; k < N; k++) if (m_csr[k][7]) m_cw1[k] = m_csr[k]; else m_cw0[k] = m_csr[k];
      end
    end
    p_ce = disp_ce; p_ck = disp_clk; p_rs = disp_rs; p_din = disp_din;
  end

  function automatic logic disp_ck_hi();
    return disp_clk;
  endfunction

  task automatic chk(input bit ok, input string r, input string msg);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: %s", r, msg); end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    #1;
  endtask

  task automatic send(input logic c, input logic [7:0] w, input logic [DOT_W-1:0] d);
    wait_ready();
    req_ctrl = c; req_word = w; req_dots = d; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    wait_ready();
  endtask

  function automatic logic [DOT_W-1:0] pat(input int p);
    logic [DOT_W-1:0] r;
    for (int k = 0; k < DOT_W/32; k++) r[k*32 +: 32] = 32'h9E3779B9 * (p + 1) ^ (32'h01010101 * k);
    if (p == 0) r = '1;
    if (p == 1) r = '0;
    if (p == 2) begin r = '0; r[DOT_W-1] = 1'b1; end
    if (p == 3) begin r = '0; r[0] = 1'b1; end
    return r;
  endfunction

  task automatic check_cw(input string r, input bit word1, input logic [7:0] exp);
    for (int k = 0; k < N; k++) begin
      logic [7:0] got;
      got = word1 ? m_cw1[k] : m_cw0[k];
      chk(got == exp, r, $sformatf("device %0d word%0d got %h exp %h", k, word1, got, exp));
    end
  endtask

  task automatic check_init();
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!disp_rst_n && n < 100);
    chk(n == RST_CYC, "R1", $sformatf("device reset release after %0d exp %0d", n, RST_CYC));
    wait_ready();
    chk(m_lat == '0, "R2", $sformatf("dot latch %h exp 0", m_lat));
    chk(last_clks == 8*N, "R2", $sformatf("init control clocks %0d exp %0d", last_clks, 8*N));
    check_cw("R2", 1'b0, {2'b01, init_level});
    chk(disp_blank == 1'b0, "R2", $sformatf("blank %b exp 0", disp_blank));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(disp_rst_n == 1'b0, "R1", $sformatf("disp_rst_n %b exp 0", disp_rst_n));
    chk(disp_ce == 1'b1 && disp_clk == 1'b0, "R1", $sformatf("ce/clk %b%b exp 10", disp_ce, disp_clk));
    chk(disp_blank == 1'b1, "R1", $sformatf("blank %b exp 1", disp_blank));
    chk(req_ready == 1'b0, "R1", $sformatf("ready %b exp 0", req_ready));
    rst_n = 1'b1;
    check_init();
    chk(xfers == 2, "R2", $sformatf("init frames %0d exp 2", xfers));

    for (int p = 0; p < 8; p++) begin
      send(1'b0, 8'h00, pat(p));
      chk(m_lat == pat(p), "R3", $sformatf("pattern %0d latch %h exp %h", p, m_lat, pat(p)));
      chk(last_clks == DOT_W, "R3", $sformatf("dot clocks %0d exp %0d", last_clks, DOT_W));
    end

    for (int v = 0; v < 128; v++) begin
      send(1'b1, 8'(v), '0);
      check_cw("R4", 1'b0, 8'(v));
      chk(last_clks == 8*N, "R4", $sformatf("serial clocks %0d exp %0d", last_clks, 8*N));
    end

    send(1'b1, 8'h81, '0);
    check_cw("R4", 1'b1, 8'h81);
    send(1'b1, 8'h35, '0);
    chk(last_clks == 8, "R5", $sformatf("broadcast clocks %0d exp 8", last_clks));
    check_cw("R5", 1'b0, 8'h35);
    send(1'b0, 8'h00, pat(9));
    chk(last_clks == DOT_W && m_lat == pat(9), "R5", $sformatf("dot in broadcast clocks %0d exp %0d", last_clks, DOT_W));
    send(1'b1, 8'h80, '0);
    chk(last_clks == 8, "R5", $sformatf("leave broadcast clocks %0d exp 8", last_clks));
    check_cw("R5", 1'b1, 8'h80);
    send(1'b1, 8'h22, '0);
    chk(last_clks == 8*N, "R5", $sformatf("serial again clocks %0d exp %0d", last_clks, 8*N));
    check_cw("R5", 1'b0, 8'h22);
    send(1'b1, 8'h81, '0);

    begin
      int x0;
      send(1'b0, 8'h00, pat(10));
      x0 = xfers;
      wait_ready();
      req_ctrl = 1'b0; req_dots = pat(11); req_valid = 1'b1;
      @(negedge clk); req_valid = 1'b0;
      @(negedge clk);
      req_dots = pat(12); req_valid = 1'b1;
      repeat (50) @(negedge clk);
      chk(req_ready == 1'b0, "R9", $sformatf("ready while busy %b exp 0", req_ready));
      req_valid = 1'b0;
      wait_ready();
      chk(xfers == x0 + 1, "R9", $sformatf("frames %0d exp %0d", xfers, x0 + 1));
      chk(m_lat == pat(11), "R9", $sformatf("latch %h exp %h", m_lat, pat(11)));
    end

    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    check_init();
    send(1'b1, 8'h40, '0);
    chk(last_clks == 8*N, "R5", $sformatf("clocks after reset %0d exp %0d", last_clks, 8*N));

    chk(v6 == 0, "R6", $sformatf("framing violations %0d exp 0", v6));
    chk(v7 == 0, "R7", $sformatf("bit timing violations %0d exp 0", v7));
    chk(v8 == 0, "R8", $sformatf("frame end violations %0d exp 0", v8));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule